// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block converts the set/reset decision of a fixed-frequency buck regulator into two gate commands, one for the high-side switch and one for the low-side switch. A one-tick pulse on `cyc_start` opens each switching period, and the period latch sets then. The latch clears when the ramp comparator asks for it (`cmp_rst`) or when a maximum-duty guard fires. A four-state machine turns the latch output into gate commands. It puts a programmable number of ticks with both gates off before either gate turns on.

Two protections shape start-up and very long on-times. The low side stays blocked after enable until either the high side has been asked to conduct or the soft-start flag `ss_done` is high. This keeps a pre-biased output from being pulled down. A guard counts how many whole switching periods the latch has stayed set. Once that count reaches a limit (20 by default), the latch is cleared at the `cyc_half` marker of the next period. The low side then conducts for the rest of that period, which recharges the bootstrap supply.

The states are IDLE (both gates off), DEAD (both gates off while the dead-time counter runs), HIGH and LOW. The transitions are as follows. IDLE goes to DEAD when enabled and there is either high-side demand or low-side permission. DEAD, once its count expires, goes to HIGH if high-side demand is present, otherwise to LOW if the low side is permitted, otherwise to IDLE. HIGH goes to DEAD when high-side demand ends. LOW goes to DEAD when high-side demand appears or low-side permission is withdrawn. Every state goes to IDLE when `en` is low.

Top module: `buck_gate_seq`

## Requirements
- R1: While `rst_n` is low, both `gate_hi` and `gate_lo` are 0.
- R2: With `en` high, a `cyc_start` pulse sets the period latch, and `gate_hi` becomes 1 within DEAD_TICKS+2 ticks.
- R3: A `cmp_rst` pulse clears the period latch, and the high side then turns off. If `cmp_rst` and `cyc_start` arrive in the same tick, the clear wins and the high side does not turn on in that period.
- R4: Between one gate turning off and the other gate turning on, both gates are off for at least DEAD_TICKS ticks. Every gate turn-on is entered from the DEAD state with its count at zero.
- R5: `gate_hi` and `gate_lo` are never 1 in the same tick.
- R6: After enable, `gate_lo` stays 0 until either the high side has been requested at least once or `ss_done` is 1.
- R7: The guard counts consecutive periods in which the latch stayed set for the whole period. A period in which the latch is clear for any tick resets the count to 0, and the count saturates at MAX_RUN.
- R8: When MAX_RUN whole periods have been counted, the latch is cleared at the `cyc_half` tick of the next period. `gate_lo` then turns on for the rest of that period, and the following period starts a fresh count.
- R9: While `en` is 0, both gates are off, the latch is clear and the start-up inhibit memory is erased. After re-enable, the low side is blocked again until R6 is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-tick pulse opening each switching period |
| cyc_half | input | 1 | One-tick pulse at the middle of each period |
| cmp_rst | input | 1 | Comparator request to end the on-time |
| ss_done | input | 1 | Soft start has passed its threshold |
| en | input | 1 | Run permission from the fault logic |
| gate_hi | output | 1 | High-side gate command |
| gate_lo | output | 1 | Low-side gate command |

## Verification
The assertions check four properties on every tick. The two gates are never on together. Every gate turn-on comes out of an expired dead interval. A new low-side turn-on needs permission in the tick before it. Low enable, a comparator clear and a forced clear each empty the latch on the next tick. Only the directed scenarios can show the period-level behaviour. These are the count of 20 whole periods followed by a mid-period clear, the count restarting after a short period, the clear winning over the set in the same tick, and the inhibit memory being erased when enable is low.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DEAD = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } gate_state_t;
endpackage

// File: rtl/bsg_duty_guard.sv
module bsg_duty_guard #(
    parameter int MAX_RUN = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_start,
    input  logic cyc_half,
    input  logic cmp_rst,
    output logic pwm_q
);
    localparam int RUN_W = $clog2(MAX_RUN + 1);

    logic [RUN_W-1:0] run_cnt;
    logic             on_all;
    logic             force_rst;

    assign force_rst = cyc_half && (run_cnt == RUN_W'(MAX_RUN));

    // period latch: clear requests take priority over the set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else if (!en || cmp_rst || force_rst) begin
            pwm_q <= 1'b0;
        end else if (cyc_start) begin
            pwm_q <= 1'b1;
        end
    end

    // whole-period run counter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_cnt <= '0;
            on_all  <= 1'b0;
        end else if (cyc_start) begin
            if (on_all && pwm_q) begin
                if (run_cnt != RUN_W'(MAX_RUN)) run_cnt <= run_cnt + 1'b1;
            end else begin
                run_cnt <= '0;
            end
            on_all <= 1'b1;
        end else if (!pwm_q) begin
            on_all <= 1'b0;
        end
    end

    p_force_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_rst |=> !pwm_q);
    p_cmp_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_rst |=> !pwm_q);
    p_run_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= RUN_W'(MAX_RUN));
    p_en_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pwm_q);
endmodule

// File: rtl/bsg_gate_fsm.sv
module bsg_gate_fsm
    import bsg_pkg::*;
#(
    parameter int DEAD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dem_hi,
    input  logic ss_done,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int CNT_W = (DEAD_TICKS > 1) ? $clog2(DEAD_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_TICKS - 1);

    gate_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             hs_tried;
    logic             lo_ok;

    assign lo_ok = ss_done || hs_tried;

    // start-up inhibit memory
    always_ff @(posedge clk) begin
        if (!rst_n || !en) hs_tried <= 1'b0;
        else if (dem_hi)   hs_tried <= 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (en && (dem_hi || lo_ok)) st_d = ST_DEAD;
            ST_DEAD: begin
                if (!en)                st_d = ST_IDLE;
                else if (cnt_q == '0) begin
                    if (dem_hi)         st_d = ST_HIGH;
                    else if (lo_ok)     st_d = ST_LOW;
                    else                st_d = ST_IDLE;
                end
            end
            ST_HIGH: begin
                if (!en)                st_d = ST_IDLE;
                else if (!dem_hi)       st_d = ST_DEAD;
            end
            ST_LOW: begin
                if (!en)                st_d = ST_IDLE;
                else if (dem_hi || !lo_ok) st_d = ST_DEAD;
            end
            default:                    st_d = ST_IDLE;
        endcase
    end

    // state register with dead-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d == ST_DEAD && st_q != ST_DEAD) cnt_q <= CNT_LOAD;
            else if (st_q == ST_DEAD && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        gate_hi = 1'b0;
        gate_lo = 1'b0;
        unique case (st_q)
            ST_HIGH: gate_hi = 1'b1;
            ST_LOW:  gate_lo = 1'b1;
            default: ;
        endcase
    end

    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
    p_dead_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi || gate_lo) && !$past(gate_hi || gate_lo))
        |-> ($past(st_q) == ST_DEAD && $past(cnt_q) == '0));
    p_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_lo && !$past(gate_lo)) |-> $past(lo_ok));
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!gate_hi && !gate_lo));
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
    parameter int DEAD_TICKS = 2,
    parameter int MAX_RUN    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic cyc_half,
    input  logic cmp_rst,
    input  logic ss_done,
    input  logic en,
    output logic gate_hi,
    output logic gate_lo
);
    logic pwm_q;

    bsg_duty_guard #(.MAX_RUN(MAX_RUN)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cyc_start (cyc_start),
        .cyc_half  (cyc_half),
        .cmp_rst   (cmp_rst),
        .pwm_q     (pwm_q)
    );

    bsg_gate_fsm #(.DEAD_TICKS(DEAD_TICKS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .dem_hi  (pwm_q),
        .ss_done (ss_done),
        .gate_hi (gate_hi),
        .gate_lo (gate_lo)
    );

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!gate_hi && !gate_lo));
endmodule

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DT         = 2;
    localparam int RUNLIM     = 20;
    localparam int CYC        = 16;
    localparam int NONE       = 99;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_start = 1'b0, cyc_half = 1'b0, cmp_rst = 1'b0;
    logic ss_done = 1'b0, en = 1'b0;
    logic gate_hi, gate_lo;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_gate_seq #(.DEAD_TICKS(DT), .MAX_RUN(RUNLIM)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_half(cyc_half),
        .cmp_rst(cmp_rst), .ss_done(ss_done), .en(en),
        .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // continuous monitor: R5 overlap, R4 gap length
    int off_run = 0;
    int last_on = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (gate_hi && gate_lo) begin
                n_chk++; n_bad++;
                $display("FAIL R5: actual both on expected exclusive");
            end
            if (!gate_hi && !gate_lo) begin
                off_run++;
            end else begin
                int cur;
                cur = gate_hi ? 1 : 2;
                if (last_on != 0 && cur != last_on) begin
                    n_chk++;
                    if (off_run < DT) begin
                        n_bad++;
                        $display("FAIL R4: actual gap %0d expected >= %0d", off_run, DT);
                    end
                end
                last_on = cur;
                off_run = 0;
            end
        end
    end

    task automatic idle_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_start = 1'b0; cyc_half = 1'b0; cmp_rst = 1'b0;
        end
    endtask

    task automatic run_cycle(input int rst_at, output logic hm, output logic hl, output logic ll);
        hm = 1'bx; hl = 1'bx; ll = 1'bx;
        for (int t = 0; t < CYC; t++) begin
            @(negedge clk);
            if (t == 6) hm = gate_hi;
            if (t == 14) begin hl = gate_hi; ll = gate_lo; end
            cyc_start = (t == 0);
            cyc_half  = (t == CYC/2);
            cmp_rst   = (t == rst_at);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en = 1'b1; ss_done = 1'b1;
        idle_ticks(4);
        chk("R1 hi in reset", gate_hi, 1'b0);
        chk("R1 lo in reset", gate_lo, 1'b0);
        en = 1'b0; ss_done = 1'b0;
        idle_ticks(2);
        rst_n = 1'b1;
        idle_ticks(2);
    endtask

    task automatic t_inhibit();
        en = 1'b1; ss_done = 1'b0;
        idle_ticks(20);
        chk("R6 lo blocked", gate_lo, 1'b0);
        chk("R6 hi idle", gate_hi, 1'b0);
        ss_done = 1'b1;
        idle_ticks(10);
        chk("R6 lo after ss flag", gate_lo, 1'b1);
    endtask

    task automatic t_basic();
        logic hm, hl, ll;
        run_cycle(6, hm, hl, ll);
        chk("R2 hi on", hm, 1'b1);
        chk("R3 hi off after cmp", hl, 1'b0);
        chk("R3 lo after cmp", ll, 1'b1);
    endtask

    task automatic t_priority();
        logic hm, hl, ll;
        en = 1'b0; ss_done = 1'b0;
        idle_ticks(3);
        en = 1'b1;
        run_cycle(0, hm, hl, ll);
        chk("R3 clear beats set", hm, 1'b0);
        chk("R6 lo blocked no attempt", ll, 1'b0);
        run_cycle(6, hm, hl, ll);
        chk("R2 hi on", hm, 1'b1);
        chk("R6 lo after hs attempt", ll, 1'b1);
    endtask

    task automatic t_enable();
        logic hm, hl, ll;
        ss_done = 1'b1; en = 1'b0;
        run_cycle(NONE, hm, hl, ll);
        chk("R9 hi off disabled", hm, 1'b0);
        chk("R9 hi off late", hl, 1'b0);
        chk("R9 lo off disabled", ll, 1'b0);
        en = 1'b1; ss_done = 1'b0;
        run_cycle(0, hm, hl, ll);
        chk("R9 inhibit memory cleared", ll, 1'b0);
    endtask

    task automatic t_runlength();
        logic hm, hl, ll;
        ss_done = 1'b1;
        for (int k = 0; k < 15; k++) run_cycle(NONE, hm, hl, ll);
        chk("R7 hi held 15 periods", hl, 1'b1);
        run_cycle(6, hm, hl, ll);
        chk("R3 short period lo", ll, 1'b1);
        for (int k = 0; k < RUNLIM; k++) begin
            run_cycle(NONE, hm, hl, ll);
            chk("R7 count restarted, hi held", hl, 1'b1);
        end
        run_cycle(NONE, hm, hl, ll);
        chk("R8 hi before midpoint", hm, 1'b1);
        chk("R8 hi forced off", hl, 1'b0);
        chk("R8 lo refresh", ll, 1'b1);
        run_cycle(NONE, hm, hl, ll);
        chk("R7 fresh count after force", hl, 1'b1);
        chk("R7 lo off in fresh period", ll, 1'b0);
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_inhibit();
        t_basic();
        t_priority();
        t_enable();
        t_runlength();
        idle_ticks(2);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule